// File: doc/BRIEF.md
# Capability Execution Mode and Register Access Controller

This block owns the capability-mode-enable and register-enable control bits that live in three configuration CSRs:
- the machine security configuration register (called `msec` here);
- the machine environment configuration register (`menv`);
- the supervisor environment configuration register (`senv`).

It serves CSR reads and writes to those registers. It also watches the current privilege level and the effective XLEN of each privilege level.

From this state the block computes two results for the current level:
- whether the hart executes in Capability or Legacy mode;
- whether explicit access to capability registers is allowed.

It raises an illegal-instruction indication in these cases:
- a capability instruction is issued while register access is off;
- a capability CSR is accessed while register access is off;
- a configuration write is attempted from a privilege level that may not make it.

Instruction decode, the capability register file and memory checks sit outside the block. They hand in one-bit classifications and consume the outputs. Implicit capability use, such as fetch and data authorisation by the last installed capabilities, is not touched by the access enable.

Top module: `cap_mode_ctrl`

## Requirements
- R1: After reset, every stored enable bit is 0. All three registers then read as zero. Every level executes in Legacy mode. Register access is off in S and U. In M it is on whenever M runs at full XLEN.
- R2: The mode enable follows the privilege level. M (code 3) uses `msec` bit 3. S (code 1) uses `menv` bit 28. U (code 0, and the unused code 2) uses `senv` bit 28. A value of 1 selects Capability mode (`cap_mode_o`=1) and 0 selects Legacy mode.
- R3: Register access (`reg_en_o`) depends on the level. In M it is always allowed. In S it follows `menv` bit 29. In U it follows `senv` bit 29.
- R4: A level runs narrow when its XLEN code is below `XL_MAX`. The codes are 1=32, 2=64 and 3=128, with `XL_MAX` defaulting to 2. A narrow level has register access off and runs in Legacy mode, whatever its enable bits say.
- R5: While `menv` bit 29 is 0, `senv` bit 29 reads as 0 and cannot be written to 1. A write that clears `menv` bit 29 also clears `senv` bit 29, and the bit stays 0 after `menv` bit 29 is set again.
- R6: While register access is off, `illegal_o` is raised for a capability instruction (`cap_insn_i`) and for a CSR request marked as a capability CSR (`csr_cap_i`). In that state `cap_mode_o` is 0 regardless of any enable bit.
- R7: With the mode extension enabled (`MODE_EXT`=1), Capability mode also requires the program-counter capability mode bit `pcc_mode_i` to be 1.
- R8: Only the bits named above can be written. Every other bit of the three registers reads as 0, and reads to any other address return 0.
- R9: The registers live at these CSR addresses: `msec` at 0x747, `menv` at 0x30A and `senv` at 0x10A. Writes to `msec` and `menv` are allowed only in M. Writes to `senv` are allowed in S and M. A write from any other level raises `illegal_o` and leaves the register unchanged.
- R10: Read data is available in the same cycle as the request. A permitted write takes effect on the next clock edge. The mode, access and trap outputs of the write cycle still reflect the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M, 2 treated as U) |
| xl_m_i | input | XL_W | XLEN code of M |
| xl_s_i | input | XL_W | XLEN code of S |
| xl_u_i | input | XL_W | XLEN code of U |
| pcc_mode_i | input | 1 | Mode bit of the program-counter capability |
| cap_insn_i | input | 1 | Current instruction is a capability instruction |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | CSR request is a write |
| csr_addr_i | input | ADDR_W | CSR address |
| csr_cap_i | input | 1 | Addressed CSR is a capability CSR |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| cap_mode_o | output | 1 | 1 = Capability mode, 0 = Legacy mode |
| reg_en_o | output | 1 | Explicit capability register access allowed |
| illegal_o | output | 1 | Illegal-instruction trap request |

## Verification
The collision of interest is a configuration write and a trap or mode decision in the same cycle. One example is M clearing `menv` bit 29 while `senv` bit 29 is set. Another is M dropping its own mode enable while the mode output is being sampled. The bench drives such a write together with capability-instruction and capability-CSR flags. It checks that the outputs of that cycle still follow the old bits, and that the new values, including the forced clearing of `senv` bit 29, show up only after the edge. A behavioural reference model updated at each edge predicts every output on every cycle, in both directed and random stimulus.

// File: rtl/cap_mode_pkg.sv
package cap_mode_pkg;
  typedef enum logic [1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_M = 2'd3
  } lvl_e;

  localparam int ADDR_W       = 12;
  localparam logic [ADDR_W-1:0] ADDR_MSEC = 12'h747;
  localparam logic [ADDR_W-1:0] ADDR_MENV = 12'h30A;
  localparam logic [ADDR_W-1:0] ADDR_SENV = 12'h10A;
  localparam int MSEC_CME_BIT = 3;
  localparam int ENV_CME_BIT  = 28;
  localparam int ENV_CRE_BIT  = 29;

  // reserved code 2 behaves as the least privileged level
  function automatic lvl_e to_lvl(logic [1:0] code);
    case (code)
      2'd3:    return LVL_M;
      2'd1:    return LVL_S;
      default: return LVL_U;
    endcase
  endfunction
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import cap_mode_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_msec_i,
  input  logic              wr_menv_i,
  input  logic              wr_senv_i,
  input  logic              wd_msec_cme_i,
  input  logic              wd_cme_i,
  input  logic              wd_cre_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              msec_cme_o,
  output logic              menv_cme_o,
  output logic              menv_cre_o,
  output logic              senv_cme_o,
  output logic              senv_cre_o,
  output logic [XLEN-1:0]   rdata_o
);
  logic msec_cme_q, menv_cme_q, menv_cre_q, senv_cme_q, senv_cre_q;
  logic msec_cme_d, menv_cme_d, menv_cre_d, senv_cme_d, senv_cre_d;

  always_comb begin
    msec_cme_d = wr_msec_i ? wd_msec_cme_i : msec_cme_q;
    menv_cme_d = wr_menv_i ? wd_cme_i : menv_cme_q;
    menv_cre_d = wr_menv_i ? wd_cre_i : menv_cre_q;
    senv_cme_d = wr_senv_i ? wd_cme_i : senv_cme_q;
    // lower enable is held at zero by the one above it
    senv_cre_d = (wr_senv_i ? wd_cre_i : senv_cre_q) & menv_cre_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msec_cme_q <= 1'b0;
      menv_cme_q <= 1'b0;
      menv_cre_q <= 1'b0;
      senv_cme_q <= 1'b0;
      senv_cre_q <= 1'b0;
    end else begin
      msec_cme_q <= msec_cme_d;
      menv_cme_q <= menv_cme_d;
      menv_cre_q <= menv_cre_d;
      senv_cme_q <= senv_cme_d;
      senv_cre_q <= senv_cre_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_req_i) begin
      unique case (rd_addr_i)
        ADDR_MSEC: rdata_o[MSEC_CME_BIT] = msec_cme_q;
        ADDR_MENV: begin
          rdata_o[ENV_CME_BIT] = menv_cme_q;
          rdata_o[ENV_CRE_BIT] = menv_cre_q;
        end
        ADDR_SENV: begin
          rdata_o[ENV_CME_BIT] = senv_cme_q;
          rdata_o[ENV_CRE_BIT] = senv_cre_q;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign msec_cme_o = msec_cme_q;
  assign menv_cme_o = menv_cme_q;
  assign menv_cre_o = menv_cre_q;
  assign senv_cme_o = senv_cme_q;
  assign senv_cre_o = senv_cre_q;
endmodule

// File: rtl/cap_mode_sel.sv
module cap_mode_sel
  import cap_mode_pkg::*;
#(
  parameter int XL_W     = 2,
  parameter int XL_MAX   = 2,
  parameter bit MODE_EXT = 1'b1
) (
  input  lvl_e            lvl_i,
  input  logic [XL_W-1:0] xl_m_i,
  input  logic [XL_W-1:0] xl_s_i,
  input  logic [XL_W-1:0] xl_u_i,
  input  logic            pcc_mode_i,
  input  logic            msec_cme_i,
  input  logic            menv_cme_i,
  input  logic            menv_cre_i,
  input  logic            senv_cme_i,
  input  logic            senv_cre_i,
  output logic            cap_mode_o,
  output logic            reg_en_o
);
  localparam logic [XL_W-1:0] XL_FULL = XL_W'(XL_MAX);

  logic [XL_W-1:0] xl_cur;
  logic            cme_cur, cre_cur, narrow, pcc_ok;

  always_comb begin
    unique case (lvl_i)
      LVL_M: begin xl_cur = xl_m_i; cme_cur = msec_cme_i; cre_cur = 1'b1;       end
      LVL_S: begin xl_cur = xl_s_i; cme_cur = menv_cme_i; cre_cur = menv_cre_i; end
      default: begin xl_cur = xl_u_i; cme_cur = senv_cme_i; cre_cur = senv_cre_i; end
    endcase
  end

  generate
    if (MODE_EXT) begin : g_pcc
      assign pcc_ok = pcc_mode_i;
    end else begin : g_no_pcc
      logic unused_pcc;
      assign unused_pcc = pcc_mode_i;
      assign pcc_ok     = 1'b1;
    end
  endgenerate

  assign narrow     = xl_cur < XL_FULL;
  assign reg_en_o   = cre_cur & ~narrow;
  assign cap_mode_o = reg_en_o & cme_cur & pcc_ok;
endmodule

// File: rtl/cap_trap_chk.sv
module cap_trap_chk
  import cap_mode_pkg::*;
(
  input  lvl_e              lvl_i,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_cap_i,
  input  logic              cap_insn_i,
  input  logic              reg_en_i,
  output logic              wr_msec_o,
  output logic              wr_menv_o,
  output logic              wr_senv_o,
  output logic              illegal_o
);
  logic wr, hit_msec, hit_menv, hit_senv, m_ok, s_ok, priv_bad, cap_bad;

  assign wr       = csr_req_i & csr_we_i;
  assign hit_msec = csr_addr_i == ADDR_MSEC;
  assign hit_menv = csr_addr_i == ADDR_MENV;
  assign hit_senv = csr_addr_i == ADDR_SENV;
  assign m_ok     = lvl_i == LVL_M;
  assign s_ok     = lvl_i != LVL_U;

  assign wr_msec_o = wr & hit_msec & m_ok;
  assign wr_menv_o = wr & hit_menv & m_ok;
  assign wr_senv_o = wr & hit_senv & s_ok;

  assign priv_bad = wr & (((hit_msec | hit_menv) & ~m_ok) | (hit_senv & ~s_ok));
  assign cap_bad  = ~reg_en_i & (cap_insn_i | (csr_req_i & csr_cap_i));
  assign illegal_o = priv_bad | cap_bad;
endmodule

// File: rtl/cap_mode_ctrl.sv
module cap_mode_ctrl
  import cap_mode_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int XL_W     = 2,
  parameter int XL_MAX   = 2,
  parameter bit MODE_EXT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        priv_i,
  input  logic [XL_W-1:0]   xl_m_i,
  input  logic [XL_W-1:0]   xl_s_i,
  input  logic [XL_W-1:0]   xl_u_i,
  input  logic              pcc_mode_i,
  input  logic              cap_insn_i,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_cap_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              cap_mode_o,
  output logic              reg_en_o,
  output logic              illegal_o
);
  lvl_e lvl;
  logic wr_msec, wr_menv, wr_senv;
  logic msec_cme, menv_cme, menv_cre, senv_cme, senv_cre;
  logic unused_wdata;

  assign lvl          = to_lvl(priv_i);
  assign unused_wdata = ^csr_wdata_i;

  cap_cfg_regs #(.XLEN(XLEN)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_msec_i     (wr_msec),
    .wr_menv_i     (wr_menv),
    .wr_senv_i     (wr_senv),
    .wd_msec_cme_i (csr_wdata_i[MSEC_CME_BIT]),
    .wd_cme_i      (csr_wdata_i[ENV_CME_BIT]),
    .wd_cre_i      (csr_wdata_i[ENV_CRE_BIT]),
    .rd_req_i      (csr_req_i),
    .rd_addr_i     (csr_addr_i),
    .msec_cme_o    (msec_cme),
    .menv_cme_o    (menv_cme),
    .menv_cre_o    (menv_cre),
    .senv_cme_o    (senv_cme),
    .senv_cre_o    (senv_cre),
    .rdata_o       (csr_rdata_o)
  );

  cap_mode_sel #(.XL_W(XL_W), .XL_MAX(XL_MAX), .MODE_EXT(MODE_EXT)) u_sel (
    .lvl_i      (lvl),
    .xl_m_i     (xl_m_i),
    .xl_s_i     (xl_s_i),
    .xl_u_i     (xl_u_i),
    .pcc_mode_i (pcc_mode_i),
    .msec_cme_i (msec_cme),
    .menv_cme_i (menv_cme),
    .menv_cre_i (menv_cre),
    .senv_cme_i (senv_cme),
    .senv_cre_i (senv_cre),
    .cap_mode_o (cap_mode_o),
    .reg_en_o   (reg_en_o)
  );

  cap_trap_chk u_trap (
    .lvl_i      (lvl),
    .csr_req_i  (csr_req_i),
    .csr_we_i   (csr_we_i),
    .csr_addr_i (csr_addr_i),
    .csr_cap_i  (csr_cap_i),
    .cap_insn_i (cap_insn_i),
    .reg_en_i   (reg_en_o),
    .wr_msec_o  (wr_msec),
    .wr_menv_o  (wr_menv),
    .wr_senv_o  (wr_senv),
    .illegal_o  (illegal_o)
  );
endmodule

// File: rtl/cap_mode_ctrl_chk.sv
module cap_mode_ctrl_chk
  import cap_mode_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int XL_W   = 2,
  parameter int XL_MAX = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        priv_i,
  input logic [XL_W-1:0]   xl_m_i,
  input logic [XL_W-1:0]   xl_s_i,
  input logic [XL_W-1:0]   xl_u_i,
  input logic              cap_insn_i,
  input logic              csr_req_i,
  input logic              csr_we_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic              cap_mode_o,
  input logic              reg_en_o,
  input logic              illegal_o,
  input logic              msec_cme,
  input logic              menv_cre,
  input logic              senv_cre
);
  localparam logic [XL_W-1:0] XL_FULL = XL_W'(XL_MAX);

  logic cur_narrow;
  always_comb begin
    unique case (priv_i)
      2'd3:    cur_narrow = xl_m_i < XL_FULL;
      2'd1:    cur_narrow = xl_s_i < XL_FULL;
      default: cur_narrow = xl_u_i < XL_FULL;
    endcase
  end

  AST_M_FULL_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd3 && !cur_narrow) |-> reg_en_o); // R3
  AST_NARROW_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_narrow |-> (!reg_en_o && !cap_mode_o)); // R4
  AST_SENV_CRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !menv_cre |-> !senv_cre); // R5
  AST_CAP_INSN_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_insn_i && !reg_en_o) |-> illegal_o); // R6
  AST_LEGACY_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode_o |-> reg_en_o); // R6
  AST_LOW_PRIV_WR_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_we_i && csr_addr_i == ADDR_MSEC && priv_i != 2'd3)
      |-> illegal_o); // R9
  AST_LOW_PRIV_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_we_i && csr_addr_i == ADDR_MSEC && priv_i != 2'd3)
      |=> $stable(msec_cme)); // R9
  AST_WR_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_we_i && csr_addr_i == ADDR_MSEC && priv_i == 2'd3)
      |=> (msec_cme == $past(csr_wdata_i[MSEC_CME_BIT]))); // R10
endmodule

bind cap_mode_ctrl cap_mode_ctrl_chk #(.XLEN(XLEN), .XL_W(XL_W), .XL_MAX(XL_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .priv_i      (priv_i),
  .xl_m_i      (xl_m_i),
  .xl_s_i      (xl_s_i),
  .xl_u_i      (xl_u_i),
  .cap_insn_i  (cap_insn_i),
  .csr_req_i   (csr_req_i),
  .csr_we_i    (csr_we_i),
  .csr_addr_i  (csr_addr_i),
  .csr_wdata_i (csr_wdata_i),
  .cap_mode_o  (cap_mode_o),
  .reg_en_o    (reg_en_o),
  .illegal_o   (illegal_o),
  .msec_cme    (msec_cme),
  .menv_cre    (menv_cre),
  .senv_cre    (senv_cre)
);

// File: tb/cap_mode_ctrl_tb.sv
module cap_mode_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int XLEN = 64;
  localparam int XL_W = 2;
  localparam int XL_MAX = 2;
  localparam logic [11:0] A_MSEC = 12'h747, A_MENV = 12'h30A, A_SENV = 12'h10A;
  localparam logic [63:0] ONES = {64{1'b1}};

  logic clk = 0, rst_ni = 0;
  logic [1:0] priv = 3;
  logic [XL_W-1:0] xl_m = 2, xl_s = 2, xl_u = 2;
  logic pcc = 1, cins = 0, req = 0, we = 0, ccsr = 0;
  logic [11:0] addr = 0;
  logic [XLEN-1:0] wdata = 0, rdata;
  logic cap_mode, reg_en, illegal;

  int total = 0, bad = 0;
  bit m_cme, e_cme, e_cre, s_cme, s_cre;

  always #(CLK_P/2) clk = ~clk;

  cap_mode_ctrl #(.XLEN(XLEN), .XL_W(XL_W), .XL_MAX(XL_MAX), .MODE_EXT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .priv_i(priv), .xl_m_i(xl_m), .xl_s_i(xl_s),
    .xl_u_i(xl_u), .pcc_mode_i(pcc), .cap_insn_i(cins), .csr_req_i(req),
    .csr_we_i(we), .csr_addr_i(addr), .csr_cap_i(ccsr), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .cap_mode_o(cap_mode), .reg_en_o(reg_en), .illegal_o(illegal));

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive, check combinational outputs against the model, update model at the edge
  task automatic cyc(string tag, logic [1:0] p, bit c_ins, bit rq, bit w,
                     logic [11:0] a, bit cc, logic [63:0] wd);
    int lvl, xl;
    bit regen, cme, capm, ill, wr_ok;
    logic [63:0] rd;
    @(negedge clk);
    priv = p; cins = c_ins; req = rq; we = w; addr = a; ccsr = cc; wdata = wd;
    #1;
    lvl = (p == 3) ? 3 : (p == 1) ? 1 : 0;
    xl  = (lvl == 3) ? int'(xl_m) : (lvl == 1) ? int'(xl_s) : int'(xl_u);
    regen = ((lvl == 3) ? 1'b1 : (lvl == 1) ? e_cre : s_cre) && (xl >= XL_MAX);
    cme   = (lvl == 3) ? m_cme : (lvl == 1) ? e_cme : s_cme;
    capm  = regen && cme && pcc;
    wr_ok = rq && w && (((a == A_MSEC || a == A_MENV) && lvl == 3) || (a == A_SENV && lvl != 0));
    ill   = (c_ins && !regen) || (rq && cc && !regen) ||
            (rq && w && (a == A_MSEC || a == A_MENV || a == A_SENV) && !wr_ok);
    rd = '0;
    if (rq) begin
      if (a == A_MSEC) rd[3] = m_cme;
      if (a == A_MENV) begin rd[28] = e_cme; rd[29] = e_cre; end
      if (a == A_SENV) begin rd[28] = s_cme; rd[29] = s_cre; end
    end
    chk(tag, "cap_mode", cap_mode, capm);
    chk(tag, "reg_en", reg_en, regen);
    chk(tag, "illegal", illegal, ill);
    chk(tag, "rdata", rdata, rd);
    @(posedge clk);
    if (wr_ok) begin
      if (a == A_MSEC) m_cme = wd[3];
      if (a == A_MENV) begin e_cme = wd[28]; e_cre = wd[29]; s_cre = s_cre & e_cre; end
      if (a == A_SENV) begin s_cme = wd[28]; s_cre = wd[29] & e_cre; end
    end
  endtask

  task automatic rd_reg(string tag, logic [1:0] p, logic [11:0] a);
    cyc(tag, p, 0, 1, 0, a, 0, 0);
  endtask

  task automatic wr_reg(string tag, logic [1:0] p, logic [11:0] a, logic [63:0] d);
    cyc(tag, p, 0, 1, 1, a, 0, d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    rd_reg("R1", 3, A_MSEC);
    rd_reg("R1", 3, A_MENV);
    rd_reg("R1", 1, A_SENV);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 1, 0, 0, 0, 0, 0);
    // R2 and R8: M enable, only bit 3 sticks
    wr_reg("R8", 3, A_MSEC, ONES);
    rd_reg("R2", 3, A_MSEC);
    wr_reg("R3", 3, A_MENV, ONES);
    rd_reg("R8", 3, A_MENV);
    cyc("R3", 1, 1, 0, 0, 0, 0, 0);
    wr_reg("R9", 1, A_SENV, ONES);
    cyc("R2", 0, 1, 1, 0, 12'h7c0, 1, 0);
    cyc("R2", 2, 0, 0, 0, 0, 0, 0);
    rd_reg("R8", 3, 12'h300);
    // R7: PCC mode bit
    pcc = 0;
    cyc("R7", 3, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    pcc = 1;
    // R4: narrow XLEN
    xl_s = 1;
    cyc("R4", 1, 1, 1, 0, 12'h7c0, 1, 0);
    xl_s = 2; xl_m = 1;
    cyc("R4", 3, 1, 0, 0, 0, 0, 0);
    xl_m = 3;
    cyc("R4", 3, 1, 0, 0, 0, 0, 0);
    xl_m = 2;
    // R9: low-privilege writes rejected and ignored
    wr_reg("R9", 0, A_SENV, 0);
    wr_reg("R9", 1, A_MENV, 0);
    wr_reg("R9", 1, A_MSEC, 0);
    rd_reg("R9", 3, A_SENV);
    rd_reg("R9", 3, A_MENV);
    rd_reg("R9", 3, A_MSEC);
    // R10: write cycle still sees old values, collides with trap sampling
    cyc("R10", 3, 1, 1, 1, A_MENV, 0, 64'h1000_0000);
    cyc("R10", 0, 1, 1, 0, A_SENV, 0, 0);
    cyc("R10", 3, 0, 1, 1, A_MSEC, 0, 0);
    cyc("R10", 3, 0, 0, 0, 0, 0, 0);
    // R5: senv CRE forced and held at zero
    rd_reg("R5", 1, A_SENV);
    wr_reg("R5", 1, A_SENV, ONES);
    rd_reg("R5", 1, A_SENV);
    wr_reg("R5", 3, A_MENV, ONES);
    rd_reg("R5", 1, A_SENV);
    cyc("R5", 0, 1, 0, 0, 0, 0, 0);
    wr_reg("R5", 1, A_SENV, ONES);
    rd_reg("R5", 0, A_SENV);
    // R6: capability CSR access and instruction with access off
    wr_reg("R6", 3, A_MENV, 0);
    cyc("R6", 1, 0, 1, 1, 12'h7c1, 1, ONES);
    cyc("R6", 0, 1, 0, 0, 0, 0, 0);
    // random phase exercises all of R1 to R10 against the model
    for (int i = 0; i < 400; i++) begin
      logic [11:0] ra;
      int sel;
      sel = $urandom_range(0, 3);
      ra = (sel == 0) ? A_MSEC : (sel == 1) ? A_MENV : (sel == 2) ? A_SENV : 12'(32'($urandom));
      xl_m = XL_W'($urandom_range(1, 3));
      xl_s = XL_W'($urandom_range(1, 3));
      xl_u = XL_W'($urandom_range(1, 3));
      pcc  = 1'($urandom);
      cyc("RND", 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ra,
          1'($urandom), {32'($urandom), 32'($urandom)});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule